// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block produces the second operand of a 32-bit data-processing instruction together with the carry that the shifter hands to the flag logic. It takes the instruction word, the value of the register being shifted and the value of the register that may supply a shift amount. A form-select input picks between two operand forms.

In the first form, an 8-bit constant from the instruction is rotated right by an even amount. In the second form, the shifted register is moved by one of four shift kinds. The amount comes either from the instruction or from the low byte of the amount register. Zero amounts written in the instruction are reused as special encodings. Amounts of 32 and above from a register follow full-range rules.

Both results are captured in output registers. They appear one clock after the inputs are applied, which suits placement at a pipeline stage boundary.

Top module: `operand_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `operand_out` and `carry_out` become 0. Otherwise the outputs at each rising edge are the result for the inputs present at that edge, so the outputs show a result one clock after its inputs.
- R2: When `imm_sel` is 1, the result is `insn[7:0]` zero-extended and rotated right by twice `insn[11:8]`. The carry is bit 31 of that result when the rotation is nonzero, and `carry_in` when the rotation is zero.
- R3: When `imm_sel` is 0, `insn[6:5]` selects the shift kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. `insn[4]`=0 takes the amount from `insn[11:7]`, and `insn[4]`=1 takes it from `rs_val[7:0]`. For amounts 1 to 31, the carry is the last bit shifted out: bit 32-n for a left shift and bit n-1 for a right shift.
- R4: An arithmetic right shift fills the vacated upper bits with copies of `rm_val[31]`.
- R5: A logical left shift with instruction amount 0 passes `rm_val` unchanged, and the carry is `carry_in`.
- R6: A logical right shift with instruction amount 0 shifts by 32. The result is 0 and the carry is `rm_val[31]`.
- R7: An arithmetic right shift with instruction amount 0 gives all ones if `rm_val[31]` is 1 and 0 otherwise. The carry is `rm_val[31]`.
- R8: A rotate right with instruction amount 0 is a one-bit rotate through the carry. The result is `{carry_in, rm_val[31:1]}` and the carry is `rm_val[0]`.
- R9: A register-supplied amount of 0 passes `rm_val` and `carry_in` through unchanged, for every shift kind.
- R10: A register-supplied amount of exactly 32 gives a result of 0 for both logical shifts. The carry is `rm_val[0]` for a left shift and `rm_val[31]` for a right shift.
- R11: For register-supplied amounts above 32, both logical shifts give 0 with carry 0. For amounts of 32 or more, an arithmetic right shift gives the sign fill, with carry `rm_val[31]`.
- R12: For a register-supplied rotate, the amount is taken modulo 32. A nonzero multiple of 32 leaves `rm_val` unchanged, with carry `rm_val[31]`. Any other amount gives carry equal to bit 31 of the rotated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word holding the operand fields |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the register that supplies a shift amount |
| imm_sel | input | 1 | 1 selects the rotated-constant form |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The hardest cases to reach are the register-supplied amounts at and beyond the word width: exactly 32, 33, 255, and nonzero multiples of 32 for rotates. A uniform random byte almost never lands on them. The stimulus therefore draws the amount byte from a weighted set that favours 0, 31, 32, 33, 64 and 255, next to fully random bytes. The instruction-amount zero encodings sit only on the field value 0. They get directed vectors for each shift kind, with both carry values and both sign values of `rm_val`.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  // instruction field positions decoded by this block
  localparam int KIND_LSB   = 5;
  localparam int KIND_W     = 2;
  localparam int AMTSRC_BIT = 4;
  localparam int SHAMT_LSB  = 7;

endpackage

// File: rtl/opsh_imm_rot.sv
module opsh_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int RSH_W = ROT_W + 1;

  logic [RSH_W-1:0]    rsh;
  logic [DATA_W-1:0]   ext;
  logic [2*DATA_W-1:0] dbl;

  always_comb begin
    rsh  = {rot, 1'b0};
    ext  = {{(DATA_W-IMM_W){1'b0}}, imm};
    dbl  = {ext, ext} >> rsh;
    res  = dbl[DATA_W-1:0];
    cout = (rot != '0) ? res[DATA_W-1] : cin;
  end
endmodule

// File: rtl/opsh_amt_dec.sv
module opsh_amt_dec
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INSN_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] rs_val,
  output shift_kind_e       kind,
  output logic [AMT_W-1:0]  amt,
  output logic              rrx
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0] imm_amt;
  logic               from_reg;

  always_comb begin
    kind     = shift_kind_e'(insn[KIND_LSB +: KIND_W]);
    from_reg = insn[AMTSRC_BIT];
    imm_amt  = insn[SHAMT_LSB +: SHAMT_W];
    rrx      = 1'b0;
    amt      = '0;
    if (from_reg) begin
      amt = rs_val[AMT_W-1:0];
    end else if (imm_amt == '0) begin
      // zero in the instruction field is reused as a special encoding
      unique case (kind)
        SH_LSR, SH_ASR: amt = AMT_W'(DATA_W);
        SH_ROR:         rrx = 1'b1;
        default:        amt = '0;
      endcase
    end else begin
      amt = {{(AMT_W-SHAMT_W){1'b0}}, imm_amt};
    end
  end
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] op,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              rrx,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [DATA_W:0]        lsl_w;
  logic [DATA_W:0]        lsr_w;
  logic signed [DATA_W:0] asr_w;
  logic [SHAMT_W-1:0]     rot_k;
  logic [2*DATA_W-1:0]    rot_d;

  always_comb begin
    // one spare bit beside the word catches the last bit shifted out
    lsl_w = {1'b0, op} << amt;
    lsr_w = {op, 1'b0} >> amt;
    asr_w = $signed({op, 1'b0}) >>> amt;
    rot_k = amt[SHAMT_W-1:0];
    rot_d = {op, op} >> rot_k;
  end

  always_comb begin
    res  = op;
    cout = cin;
    if (rrx) begin
      res  = {cin, op[DATA_W-1:1]};
      cout = op[0];
    end else if (amt != '0) begin
      unique case (kind)
        SH_LSL: begin
          res  = lsl_w[DATA_W-1:0];
          cout = lsl_w[DATA_W];
        end
        SH_LSR: begin
          res  = lsr_w[DATA_W:1];
          cout = lsr_w[0];
        end
        SH_ASR: begin
          res  = asr_w[DATA_W:1];
          cout = asr_w[0];
        end
        default: begin
          res  = rot_d[DATA_W-1:0];
          cout = rot_d[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INSN_W = 32,
  parameter int AMT_W  = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       insn,
  input  logic [31:0]       rm_val,
  input  logic [31:0]       rs_val,
  input  logic              imm_sel,
  input  logic              carry_in,
  output logic [31:0]       operand_out,
  output logic              carry_out
);
  logic [DATA_W-1:0] imm_res;
  logic              imm_c;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt;
  logic              rrx;

  opsh_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm  (insn[IMM_W-1:0]),
    .rot  (insn[IMM_W +: ROT_W]),
    .cin  (carry_in),
    .res  (imm_res),
    .cout (imm_c)
  );

  opsh_amt_dec #(.DATA_W(DATA_W), .INSN_W(INSN_W), .AMT_W(AMT_W)) u_dec (
    .insn   (insn),
    .rs_val (rs_val),
    .kind   (kind),
    .amt    (amt),
    .rrx    (rrx)
  );

  opsh_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_bar (
    .op   (rm_val),
    .kind (kind),
    .amt  (amt),
    .rrx  (rrx),
    .cin  (carry_in),
    .res  (sh_res),
    .cout (sh_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      operand_out <= '0;
      carry_out   <= 1'b0;
    end else if (imm_sel) begin
      operand_out <= imm_res;
      carry_out   <= imm_c;
    end else begin
      operand_out <= sh_res;
      carry_out   <= sh_c;
    end
  end
endmodule

// File: rtl/operand_shifter_sva.sv
module opsh_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] insn,
  input logic [31:0] rm_val,
  input logic [31:0] rs_val,
  input logic        imm_sel,
  input logic        carry_in,
  input logic [31:0] operand_out,
  input logic        carry_out
);
  logic imm_amt_zero;
  assign imm_amt_zero = !imm_sel && !insn[4] && (insn[11:7] == 5'd0);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (operand_out == 32'd0) && !carry_out);

  p_zero_rot_r2: assert property (@(posedge clk) disable iff (rst)
    (imm_sel && insn[11:8] == 4'd0) |=>
      (operand_out == {24'd0, $past(insn[7:0])}) && (carry_out == $past(carry_in)));

  p_lsr32_r6: assert property (@(posedge clk) disable iff (rst)
    (imm_amt_zero && insn[6:5] == 2'd1) |=>
      (operand_out == 32'd0) && (carry_out == $past(rm_val[31])));

  p_asr_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (imm_amt_zero && insn[6:5] == 2'd2) |=>
      (operand_out == {32{$past(rm_val[31])}}) && (carry_out == $past(rm_val[31])));

  p_rrx_r8: assert property (@(posedge clk) disable iff (rst)
    (imm_amt_zero && insn[6:5] == 2'd3) |=>
      (operand_out[31] == $past(carry_in)) && (carry_out == $past(rm_val[0])));

  p_reg_zero_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (!imm_sel && insn[4] && rs_val[7:0] == 8'd0) |=>
      (operand_out == $past(rm_val)) && (carry_out == $past(carry_in)));

  p_logic_over_r11: assert property (@(posedge clk) disable iff (rst)
    (!imm_sel && insn[4] && !insn[6] && rs_val[7:0] > 8'd32) |=>
      (operand_out == 32'd0) && !carry_out);
endmodule

bind operand_shifter opsh_checker u_opsh_checker (
  .clk         (clk),
  .rst         (rst),
  .insn        (insn),
  .rm_val      (rm_val),
  .rs_val      (rs_val),
  .imm_sel     (imm_sel),
  .carry_in    (carry_in),
  .operand_out (operand_out),
  .carry_out   (carry_out)
);

// File: tb/tb_operand_shifter.sv
module tb_operand_shifter;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] insn;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        imm_sel;
  logic        carry_in;
  logic [31:0] operand_out;
  logic        carry_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  operand_shifter dut (
    .clk (clk), .rst (rst), .insn (insn), .rm_val (rm_val), .rs_val (rs_val),
    .imm_sel (imm_sel), .carry_in (carry_in),
    .operand_out (operand_out), .carry_out (carry_out)
  );

  // behavioural reference: bit-at-a-time shifting
  function automatic logic [32:0] model(logic [31:0] iw, logic [31:0] rm,
                                        logic [31:0] rs, logic isel, logic cin);
    logic [31:0] v;
    logic        c;
    int          n;
    c = cin;
    if (isel) begin
      v = {24'd0, iw[7:0]};
      n = 2 * int'(iw[11:8]);
      for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      if (n != 0) c = v[31];
      return {c, v};
    end
    v = rm;
    if (iw[4]) n = int'(rs[7:0]);
    else begin
      n = int'(iw[11:7]);
      if (n == 0) begin
        if (iw[6:5] == 2'd1 || iw[6:5] == 2'd2) n = 32;
        if (iw[6:5] == 2'd3) return {rm[0], cin, rm[31:1]};
      end
    end
    for (int i = 0; i < n; i++) begin
      case (iw[6:5])
        2'd0: begin c = v[31]; v = v << 1; end
        2'd1: begin c = v[0];  v = v >> 1; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic string req_of(logic [31:0] iw, logic [31:0] rs, logic isel);
    int n;
    if (isel) return "R2";
    if (iw[4]) begin
      n = int'(rs[7:0]);
      if (n == 0) return "R9";
      if (iw[6:5] == 2'd3) return "R12";
      if (n == 32 && !iw[6]) return "R10";
      if (n > 32 || (n == 32 && iw[6:5] == 2'd2)) return "R11";
    end else if (iw[11:7] == 5'd0) begin
      case (iw[6:5])
        2'd0: return "R5";
        2'd1: return "R6";
        2'd2: return "R7";
        default: return "R8";
      endcase
    end
    if (iw[6:5] == 2'd2) return "R4";
    return "R3";
  endfunction

  function automatic logic [31:0] sh_word(int kind, int amt5, logic from_reg);
    return {20'd0, 5'(amt5), 2'(kind), from_reg, 4'd0};
  endfunction

  function automatic logic [31:0] imm_word(int rot, int imm);
    return {20'd0, 4'(rot), 8'(imm)};
  endfunction

  task automatic apply(logic [31:0] iw, logic [31:0] rm, logic [31:0] rs,
                       logic isel, logic cin);
    logic [32:0] exp;
    string       tag;
    insn = iw; rm_val = rm; rs_val = rs; imm_sel = isel; carry_in = cin;
    exp = model(iw, rm, rs, isel, cin);
    tag = req_of(iw, rs, isel);
    @(negedge clk);
    checks++;
    if (operand_out !== exp[31:0] || carry_out !== exp[32]) begin
      fails++;
      $display("FAIL %s insn=%h rm=%h rs=%h: actual %h/%b expected %h/%b",
               tag, iw, rm, rs, operand_out, carry_out, exp[31:0], exp[32]);
    end
  endtask

  function automatic logic [7:0] pick_amt();
    case ($urandom_range(0, 7))
      0: return 8'd0;
      1: return 8'd31;
      2: return 8'd32;
      3: return 8'd33;
      4: return 8'd64;
      5: return 8'd255;
      6: return 8'($urandom_range(1, 31));
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; insn = '0; rm_val = 32'hDEAD_BEEF; rs_val = '0;
    imm_sel = 1'b0; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (operand_out !== 32'd0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %h/%b expected 00000000/0", operand_out, carry_out);
    end
    rst = 1'b0;

    // R2 rotated constant, zero and nonzero rotations
    apply(imm_word(0, 8'hA5), '0, '0, 1'b1, 1'b1);
    apply(imm_word(1, 8'h03), '0, '0, 1'b1, 1'b0);
    apply(imm_word(4, 8'hFF), '0, '0, 1'b1, 1'b0);
    apply(imm_word(15, 8'h81), '0, '0, 1'b1, 1'b0);
    // R3 and R4 ordinary amounts
    apply(sh_word(0, 1, 0), 32'h8000_0001, '0, 1'b0, 1'b0);
    apply(sh_word(1, 31, 0), 32'hC000_0000, '0, 1'b0, 1'b0);
    apply(sh_word(2, 4, 0), 32'h8000_00F8, '0, 1'b0, 1'b0);
    apply(sh_word(3, 8, 0), 32'h1234_5680, '0, 1'b0, 1'b0);
    apply(sh_word(0, 0, 1), 32'h0000_0003, 32'h1F, 1'b0, 1'b0);
    // R5..R8 instruction-amount zero encodings
    for (int cin = 0; cin < 2; cin++) begin
      apply(sh_word(0, 0, 0), 32'h8765_4321, '0, 1'b0, 1'(cin));
      apply(sh_word(1, 0, 0), 32'h8000_0000, '0, 1'b0, 1'(cin));
      apply(sh_word(2, 0, 0), 32'h8000_0000, '0, 1'b0, 1'(cin));
      apply(sh_word(2, 0, 0), 32'h7FFF_FFFF, '0, 1'b0, 1'(cin));
      apply(sh_word(3, 0, 0), 32'h0000_0003, '0, 1'b0, 1'(cin));
    end
    // R9..R12 register amounts at the edges
    for (int k = 0; k < 4; k++) begin
      apply(sh_word(k, 0, 1), 32'hF000_000F, 32'h0000_0100, 1'b0, 1'b1);
      apply(sh_word(k, 0, 1), 32'h8000_0001, 32'd32, 1'b0, 1'b0);
      apply(sh_word(k, 0, 1), 32'hFFFF_FFFF, 32'd33, 1'b0, 1'b1);
      apply(sh_word(k, 0, 1), 32'h8000_0001, 32'd64, 1'b0, 1'b0);
      apply(sh_word(k, 0, 1), 32'h8000_0001, 32'd255, 1'b0, 1'b1);
      apply(sh_word(k, 0, 1), 32'h4000_0002, 32'd97, 1'b0, 1'b0);
    end

    // weighted random mix
    for (int t = 0; t < 600; t++) begin
      logic isel;
      logic [31:0] iw;
      isel = ($urandom_range(0, 3) == 0);
      iw = $urandom;
      if (!isel && $urandom_range(0, 2) == 0) iw[11:7] = 5'd0;
      apply(iw, $urandom, {24'($urandom), pick_amt()}, isel, 1'($urandom));
    end

    // R1 reset in the middle of traffic
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (operand_out !== 32'd0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R1 mid reset: actual %h/%b expected 00000000/0", operand_out, carry_out);
    end
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule